// File: doc/BRIEF.md
# Cross-Domain Synchronous Timer Start

This block starts a chosen set of counter channels together when those channels sit in two timer units on separate clocks. The primary unit runs on `clk_p`. The secondary unit runs on `clk_s`, which is an integer multiple (`RATIO`) of `clk_p` and phase-aligned with it, so every primary rising edge coincides with a secondary rising edge. Each unit has its own run-enable register. The primary unit also holds a trigger register with one bit per channel across both units.

The intended use has three steps. First, software halts the target channels by clearing their run-enable bits. Second, it sets them up. Third, it writes ones into the trigger register. One primary clock after that write, the run-enable bits of every selected channel are set in both units. Each selected counter takes its first increment on that same aligned edge. Trigger bits clear themselves, so they never stop a channel. A channel stops only when its own run-enable bit is cleared.

Top module: `xss_sync_start`

## Requirements
- R1: On the primary write port, `p_wr_addr`=0 overwrites the primary run-enable register with `p_wr_data[4:0]` (bit i = primary channel i). `p_wr_addr`=1 writes the trigger register. In that register, bit i (0 to 4) selects primary channel i, and bits 5, 6 and 7 select secondary channels 3, 4 and 5, which are `s_run`/`s_cnt` index 0, 1 and 2.
- R2: When a trigger write is taken on primary edge k, no run bit changes at edge k. At edge k+1 the run bits of all selected channels in both units are set, and each selected counter increments on edge k+1 itself.
- R3: Channels started by one trigger write stay aligned at every later primary edge. The selected primary counters are equal to each other, and so are the selected secondary counters. Each secondary count equals `RATIO`*(primary count - 1) + 1.
- R4: Trigger bits clear themselves one primary clock after they act. Writing 0 to the trigger register changes no run bit and stops no counter.
- R5: A trigger bit written to 1 for a channel that is already running leaves that channel's count sequence unchanged.
- R6: A running channel stops only when its run bit is cleared directly. Primary channels are cleared through `p_wr_addr`=0. Secondary channels are cleared through `s_wr_en`/`s_wr_data`, where bit j is secondary index j. A stopped counter holds its value.
- R7: A running counter increments by one on every rising edge of its own unit's clock and wraps modulo 2^`CNT_W`.
- R8: While `rst_n` is low, all run bits, all trigger bits and all counts are 0.
- R9: If a run-enable write clears a bit on the same edge where a trigger bit for that channel acts, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_p | input | 1 | Primary unit clock |
| clk_s | input | 1 | Secondary unit clock, RATIO times clk_p, rising edges aligned |
| rst_n | input | 1 | Synchronous active-low reset, sampled in both domains |
| p_wr_en | input | 1 | Primary register write strobe |
| p_wr_addr | input | 1 | 0: primary run-enable, 1: trigger register |
| p_wr_data | input | 8 | Primary write data |
| s_wr_en | input | 1 | Secondary run-enable write strobe (clk_s domain) |
| s_wr_data | input | 3 | Secondary run-enable value |
| p_run | output | 5 | Primary run-enable bits |
| s_run | output | 3 | Secondary run-enable bits |
| p_cnt | output | 80 | Primary counters, channel i at [16*i +: 16] |
| s_cnt | output | 48 | Secondary counters, index j at [16*j +: 16] |

## Verification
The assertions assume two things about the inputs. The clocks keep their integer ratio with rising edges aligned. Each secondary write is stable across every secondary edge that falls between two primary edges. The bench builds both clocks from a single time base so that every primary rising edge lands on a secondary rising edge. It drives all inputs one nanosecond after a primary edge and holds each secondary write for a whole primary period. Random traffic mixes trigger writes, run-enable writes and secondary clears, so starts collide with stops and with channels that are already running.

// File: rtl/xss_pkg.sv
`timescale 1ns/1ps
// Shared types for the cross-domain synchronous start block.
// Assumes a one-bit register select on the primary write port.
package xss_pkg;
    typedef enum logic {
        SEL_RUN  = 1'b0,
        SEL_TRIG = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/xss_primary_ctrl.sv
`timescale 1ns/1ps
// Primary-domain control: holds the trigger register and the primary
// run-enable register. It also produces a toggle that the secondary
// domain uses to find aligned edges.
// Assumes the write port is synchronous to clk.
module xss_primary_ctrl
    import xss_pkg::*;
#(
    parameter int P_CH = 5,
    parameter int S_CH = 3,
    localparam int TRIG_W = P_CH + S_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [TRIG_W-1:0] wr_data,
    output logic [P_CH-1:0]   run,
    output logic [P_CH-1:0]   kick,
    output logic [S_CH-1:0]   s_req,
    output logic              tog
);
    logic [TRIG_W-1:0] trig_q;
    logic              wr_run;
    logic              wr_trig;

    // Decode the register select.
    always_comb begin
        wr_run  = wr_en && (reg_sel_e'(wr_addr) == SEL_RUN);
        wr_trig = wr_en && (reg_sel_e'(wr_addr) == SEL_TRIG);
    end

    // Split the trigger register into its primary and secondary parts.
    always_comb begin
        kick  = trig_q[P_CH-1:0];
        s_req = trig_q[TRIG_W-1:P_CH];
    end

    // Trigger bits live for exactly one primary cycle, then clear.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= '0;
        else        trig_q <= wr_trig ? wr_data : '0;
    end

    // Run bits follow direct writes; a trigger that is acting ORs on top.
    always_ff @(posedge clk) begin
        if (!rst_n) run <= '0;
        else        run <= (wr_run ? wr_data[P_CH-1:0] : run) | kick;
    end

    // Toggle on every primary edge so the secondary side can track phase.
    always_ff @(posedge clk) begin
        if (!rst_n) tog <= 1'b0;
        else        tog <= ~tog;
    end
endmodule

// File: rtl/xss_secondary_ctrl.sv
`timescale 1ns/1ps
// Secondary-domain control: finds which clk_s edge coincides with a
// primary edge and takes the trigger request on that edge only.
// Assumes clk_s = RATIO * clk_p with aligned rising edges, and reset
// released in both domains within one primary period.
module xss_secondary_ctrl #(
    parameter int S_CH  = 3,
    parameter int RATIO = 2,
    localparam int PH_W = (RATIO > 1) ? $clog2(RATIO) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            p_tog,
    input  logic [S_CH-1:0] req,
    input  logic            wr_en,
    input  logic [S_CH-1:0] wr_data,
    output logic [S_CH-1:0] run,
    output logic [S_CH-1:0] kick
);
    logic            tog_seen;
    logic [PH_W-1:0] phase;
    logic [PH_W-1:0] phase_now;

    // Index of the current edge within a primary period (0 = aligned).
    always_comb begin
        if (p_tog != tog_seen)
            phase_now = (RATIO == 1) ? '0 : PH_W'(1);
        else if (phase == PH_W'(RATIO - 1))
            phase_now = '0;
        else
            phase_now = phase + PH_W'(1);
        kick = (phase_now == '0) ? req : '0;
    end

    // Track the primary toggle and the phase of the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog_seen <= 1'b0;
            phase    <= '0;
        end else begin
            tog_seen <= p_tog;
            phase    <= phase_now;
        end
    end

    // Run bits follow direct writes; an aligned trigger ORs on top.
    always_ff @(posedge clk) begin
        if (!rst_n) run <= '0;
        else        run <= (wr_en ? wr_data : run) | kick;
    end
endmodule

// File: rtl/xss_counter.sv
`timescale 1ns/1ps
// Free-running up-counter for one channel. It counts while run is set
// or on the edge where a start kick arrives, and wraps at 2^W.
module xss_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         kick,
    output logic [W-1:0] cnt
);
    // Count up whenever enabled by run or by a starting kick.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (run || kick) cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/xss_sync_start.sv
`timescale 1ns/1ps
// Top: two timer units on phase-aligned clocks. A primary trigger
// register starts channels in both units on the same aligned edge.
// Assumes clk_s = RATIO * clk_p with coincident rising edges.
module xss_sync_start #(
    parameter int P_CH  = 5,
    parameter int S_CH  = 3,
    parameter int CNT_W = 16,
    parameter int RATIO = 2,
    localparam int TRIG_W = P_CH + S_CH
) (
    input  logic                  clk_p,
    input  logic                  clk_s,
    input  logic                  rst_n,
    input  logic                  p_wr_en,
    input  logic                  p_wr_addr,
    input  logic [TRIG_W-1:0]     p_wr_data,
    input  logic                  s_wr_en,
    input  logic [S_CH-1:0]       s_wr_data,
    output logic [P_CH-1:0]       p_run,
    output logic [S_CH-1:0]       s_run,
    output logic [P_CH*CNT_W-1:0] p_cnt,
    output logic [S_CH*CNT_W-1:0] s_cnt
);
    logic [P_CH-1:0] p_kick;
    logic [S_CH-1:0] s_req;
    logic [S_CH-1:0] s_kick;
    logic            p_tog;

    xss_primary_ctrl #(.P_CH(P_CH), .S_CH(S_CH)) i_pctl (
        .clk(clk_p), .rst_n(rst_n),
        .wr_en(p_wr_en), .wr_addr(p_wr_addr), .wr_data(p_wr_data),
        .run(p_run), .kick(p_kick), .s_req(s_req), .tog(p_tog)
    );

    xss_secondary_ctrl #(.S_CH(S_CH), .RATIO(RATIO)) i_sctl (
        .clk(clk_s), .rst_n(rst_n), .p_tog(p_tog), .req(s_req),
        .wr_en(s_wr_en), .wr_data(s_wr_data),
        .run(s_run), .kick(s_kick)
    );

    for (genvar i = 0; i < P_CH; i++) begin : g_pcnt
        xss_counter #(.W(CNT_W)) i_cnt (
            .clk(clk_p), .rst_n(rst_n), .run(p_run[i]), .kick(p_kick[i]),
            .cnt(p_cnt[i*CNT_W +: CNT_W])
        );
    end

    for (genvar j = 0; j < S_CH; j++) begin : g_scnt
        xss_counter #(.W(CNT_W)) i_cnt (
            .clk(clk_s), .rst_n(rst_n), .run(s_run[j]), .kick(s_kick[j]),
            .cnt(s_cnt[j*CNT_W +: CNT_W])
        );
    end
endmodule

// File: rtl/xss_sync_start_chk.sv
`timescale 1ns/1ps
// Assertion checker for xss_sync_start, attached through bind.
module xss_sync_start_chk
    import xss_pkg::*;
#(
    parameter int P_CH  = 5,
    parameter int S_CH  = 3,
    parameter int CNT_W = 16,
    localparam int TRIG_W = P_CH + S_CH
) (
    input logic                  clk_p,
    input logic                  clk_s,
    input logic                  rst_n,
    input logic                  p_wr_en,
    input logic                  p_wr_addr,
    input logic [TRIG_W-1:0]     p_wr_data,
    input logic                  s_wr_en,
    input logic [P_CH-1:0]       p_run,
    input logic [S_CH-1:0]       s_run,
    input logic [P_CH*CNT_W-1:0] p_cnt,
    input logic [S_CH*CNT_W-1:0] s_cnt
);
    // R2
    trig_sets_run_chk: assert property (@(posedge clk_p) disable iff (!rst_n)
        (p_wr_en && p_wr_addr == SEL_TRIG) ##1 !(p_wr_en && p_wr_addr == SEL_RUN)
        |=> ((p_run & $past(p_wr_data[P_CH-1:0], 2)) == $past(p_wr_data[P_CH-1:0], 2)));

    // R6
    p_run_hold_chk: assert property (@(posedge clk_p) disable iff (!rst_n)
        !(p_wr_en && p_wr_addr == SEL_RUN) |=> ((p_run & $past(p_run)) == $past(p_run)));

    // R6
    s_run_hold_chk: assert property (@(posedge clk_s) disable iff (!rst_n)
        !s_wr_en |=> ((s_run & $past(s_run)) == $past(s_run)));

    for (genvar i = 0; i < P_CH; i++) begin : g_pchk
        // R7
        p_count_step_chk: assert property (@(posedge clk_p) disable iff (!rst_n)
            p_run[i] |=> p_cnt[i*CNT_W +: CNT_W] == $past(p_cnt[i*CNT_W +: CNT_W]) + CNT_W'(1));
    end

    for (genvar j = 0; j < S_CH; j++) begin : g_schk
        // R7
        s_count_step_chk: assert property (@(posedge clk_s) disable iff (!rst_n)
            s_run[j] |=> s_cnt[j*CNT_W +: CNT_W] == $past(s_cnt[j*CNT_W +: CNT_W]) + CNT_W'(1));
    end
endmodule

bind xss_sync_start xss_sync_start_chk #(.P_CH(P_CH), .S_CH(S_CH), .CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_xss_sync_start.sv
`timescale 1ns/1ps
module test_xss_sync_start;
    localparam int P_CH  = 5;
    localparam int S_CH  = 3;
    localparam int CNT_W = 16;
    localparam int RATIO = 2;
    localparam int PHALF = 4;
    localparam int SHALF = PHALF / RATIO;
    localparam int MASK  = (1 << CNT_W) - 1;

    logic clk_p = 1'b0;
    logic clk_s = 1'b1;
    logic rst_n = 1'b0;
    logic p_wr_en = 1'b0, p_wr_addr = 1'b0;
    logic [7:0] p_wr_data = '0;
    logic s_wr_en = 1'b0;
    logic [2:0] s_wr_data = '0;
    logic [P_CH-1:0] p_run;
    logic [S_CH-1:0] s_run;
    logic [P_CH*CNT_W-1:0] p_cnt;
    logic [S_CH*CNT_W-1:0] s_cnt;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [7:0]      m_trig;
    logic [P_CH-1:0] m_prun;
    logic [S_CH-1:0] m_srun;
    int              m_pcnt [P_CH];
    int              m_scnt [S_CH];

    always #(PHALF) clk_p = ~clk_p;
    always #(SHALF) clk_s = ~clk_s;

    xss_sync_start #(.P_CH(P_CH), .S_CH(S_CH), .CNT_W(CNT_W), .RATIO(RATIO)) i_xss_sync_start (
        .clk_p(clk_p), .clk_s(clk_s), .rst_n(rst_n),
        .p_wr_en(p_wr_en), .p_wr_addr(p_wr_addr), .p_wr_data(p_wr_data),
        .s_wr_en(s_wr_en), .s_wr_data(s_wr_data),
        .p_run(p_run), .s_run(s_run), .p_cnt(p_cnt), .s_cnt(s_cnt)
    );

    function automatic int bump(input int c, input bit en);
        return en ? ((c + 1) & MASK) : c;
    endfunction

    function automatic int pc(input int i);
        return int'(p_cnt[i*CNT_W +: CNT_W]);
    endfunction

    function automatic int sc(input int j);
        return int'(s_cnt[j*CNT_W +: CNT_W]);
    endfunction

    // Expected secondary count for a given primary count after a joint start (R3).
    function automatic int s_from_p(input int p);
        return (RATIO * (p - 1) + 1) & MASK;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_trig = '0; m_prun = '0; m_srun = '0;
        foreach (m_pcnt[i]) m_pcnt[i] = 0;
        foreach (m_scnt[j]) m_scnt[j] = 0;
    endtask

    // One primary period of stimulus, then a model step and a full compare (R1, R7).
    task automatic cycle(input bit we, input bit wa, input logic [7:0] wd,
                         input bit swe, input logic [2:0] swd);
        logic [S_CH-1:0] req;
        logic [P_CH-1:0] kick;
        p_wr_en = we; p_wr_addr = wa; p_wr_data = wd;
        s_wr_en = swe; s_wr_data = swd;
        @(posedge clk_p); #1;
        p_wr_en = 1'b0; s_wr_en = 1'b0;
        req = m_trig[7:5];
        for (int e = 1; e <= RATIO; e++) begin
            logic [S_CH-1:0] k;
            k = (e == RATIO) ? req : '0;
            for (int j = 0; j < S_CH; j++) m_scnt[j] = bump(m_scnt[j], m_srun[j] | k[j]);
            m_srun = (swe ? swd : m_srun) | k;
        end
        kick = m_trig[4:0];
        for (int i = 0; i < P_CH; i++) m_pcnt[i] = bump(m_pcnt[i], m_prun[i] | kick[i]);
        m_prun = ((we && !wa) ? wd[4:0] : m_prun) | kick;
        m_trig = (we && wa) ? wd : 8'h00;
        chk("R1 p_run", int'(p_run), int'(m_prun));
        chk("R1 s_run", int'(s_run), int'(m_srun));
        for (int i = 0; i < P_CH; i++) chk("R7 p_cnt", pc(i), m_pcnt[i]);
        for (int j = 0; j < S_CH; j++) chk("R7 s_cnt", sc(j), m_scnt[j]);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cycle(0, 0, 8'h00, 0, 3'b000);
    endtask

    initial begin
        #(2 * PHALF * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        int seed_val;
        model_reset();
        repeat (4) @(posedge clk_p);
        #1;
        // R8 reset state
        chk("R8 p_run", int'(p_run), 0);
        chk("R8 s_run", int'(s_run), 0);
        chk("R8 p_cnt0", pc(0), 0);
        chk("R8 s_cnt2", sc(2), 0);
        rst_n = 1'b1;

        // R2: trigger ch0, ch2 and secondary index 0, 2 (bits 5, 7)
        cycle(1, 1, 8'b1010_0101, 0, 3'b000);
        chk("R2 no start at write edge", int'(p_run), 0);
        chk("R2 no secondary start", int'(s_run), 0);
        cycle(0, 0, 8'h00, 0, 3'b000);
        chk("R2 p_run set", int'(p_run), 5'b00101);
        chk("R2 s_run set", int'(s_run), 3'b101);
        chk("R2 first tick p0", pc(0), 1);
        chk("R2 first tick s0", sc(0), 1);
        chk("R2 unselected p1", pc(1), 0);
        for (int k = 0; k < 4; k++) begin
            cycle(0, 0, 8'h00, 0, 3'b000);
            chk("R3 p0==p2", pc(0), pc(2));
            chk("R3 s0==s2", sc(0), sc(2));
            chk("R3 s vs p", sc(0), s_from_p(pc(0)));
        end

        // R4: writing zero to trigger register stops nothing
        cycle(1, 1, 8'h00, 0, 3'b000);
        idle(2);
        chk("R4 p_run kept", int'(p_run), 5'b00101);
        chk("R4 s_run kept", int'(s_run), 3'b101);
        chk("R4 still aligned", sc(2), s_from_p(pc(2)));

        // R5: retrigger ch0 and secondary 0 while running
        cycle(1, 1, 8'b0010_0001, 0, 3'b000);
        idle(2);
        chk("R5 p0 unchanged seq", pc(0), pc(2));
        chk("R5 s0 unchanged seq", sc(0), sc(2));

        // R6: stop primary ch2 and secondary index 2 directly
        cycle(1, 0, 8'b0000_0001, 1, 3'b001);
        begin
            int hp, hs;
            hp = pc(2); hs = sc(2);
            idle(3);
            chk("R6 p2 holds", pc(2), hp);
            chk("R6 s2 holds", sc(2), hs);
            chk("R6 p_run", int'(p_run), 5'b00001);
        end

        // R9: run write clears ch1 on the edge its trigger acts
        cycle(1, 1, 8'b0000_0010, 0, 3'b000);
        cycle(1, 0, 8'b0000_0000, 0, 3'b000);
        chk("R9 trigger wins", int'(p_run[1]), 1);

        // Constrained random mix
        seed_val = $urandom(32'd20240611);
        for (int n = 0; n < 600; n++) begin
            int r;
            r = $urandom_range(0, 9);
            case (r)
                3, 4:    cycle(1, 1, 8'($urandom), 0, 3'b000);
                5:       cycle(1, 0, 8'($urandom), 0, 3'b000);
                6:       cycle(0, 0, 8'h00, 1, 3'($urandom));
                7:       cycle(1, 1, 8'($urandom), 1, 3'($urandom));
                8:       cycle(1, 0, 8'($urandom), 1, 3'($urandom));
                default: cycle(0, 0, 8'h00, 0, 3'b000);
            endcase
        end

        // R3 after a fresh joint start following reset
        rst_n = 1'b0;
        model_reset();
        repeat (2) @(posedge clk_p);
        #1;
        chk("R8 cleared again", pc(4), 0);
        rst_n = 1'b1;
        cycle(1, 1, 8'hFF, 0, 3'b000);
        for (int k = 0; k < 5; k++) begin
            cycle(0, 0, 8'h00, 0, 3'b000);
            chk("R3 p4==p0", pc(4), pc(0));
            chk("R3 s1 vs p3", sc(1), s_from_p(pc(3)));
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule